// File: doc/BRIEF.md
# Outbound Address Window Translator

This block converts local addresses from a memory-mapped region into wider bus addresses. The conversion uses a table of equal-sized windows. Software first sets a region base and a power-of-two window size. It then fills each window entry with a target base split into a low and a high word; bit 0 of the low word marks the entry as usable. Last, software sets one enable bit in a control word. Until that bit is set, every lookup is reported as a miss.

A lookup presents a local address for one cycle. The block subtracts the region base and shifts the result right by the window size to pick an entry. If the entry is usable and translation is on, the block adds the address's position inside the window to the entry's 64-bit target base. The result comes out one clock later, flagged either as a hit or as a miss.

Software normally fills the entries one after another from the start of the region. Each entry's target advances by one window size, and filling stops at the region end or at the last entry.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset, every register reads as 0, translation is off, and `rs_valid`, `rs_hit` and `rs_miss` are low.
- R2: Register map (byte offsets, 32-bit words):
  - Control word at 0x004: all 32 bits are stored and read back.
  - Size code at 0x030: bits [2:0] are stored, and the upper bits read as 0.
  - Region base at 0x034: all 32 bits are stored and read back.
  - Entry n: low word at 0x200+8·n and high word at 0x204+8·n, for n from 0 to 31.
  - Any other offset reads as 0, and writes to it change nothing.
- R3: The window size is 2^code MB, that is 2^(20+code) bytes. The entry index is (address − region base) >> (20+code).
- R4: A lookup hits when all of the following hold:
  - translation is on;
  - the address lies inside the table span;
  - the selected entry's low word has bit 0 set.
  On a hit, `rs_addr` = {high word, low word with bit 0 cleared} + ((address − base) mod window size).
- R5: While control bit 1 is 0, every lookup reports a miss with `rs_addr` = 0.
- R6: A lookup that selects an entry whose low-word bit 0 is 0 reports a miss with `rs_addr` = 0.
- R7: An address below the region base, or at or above base + 32 windows, reports a miss with `rs_addr` = 0.
- R8: Each lookup gives exactly one result, one clock after `lk_valid`, with exactly one of hit and miss set. In a cycle with no result, `rs_valid`, `rs_hit` and `rs_miss` are all low.
- R9: A new size code is used by the first lookup issued after the write's clock edge.
- R10: Only bit 1 of the control word enables translation. The other control bits have no effect on lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Local address to translate |
| rs_valid | output | 1 | Lookup result valid |
| rs_hit | output | 1 | Translation succeeded |
| rs_miss | output | 1 | Translation refused |
| rs_addr | output | 64 | Translated bus address (0 on miss) |

## Verification
A corrupted entry, region base or size code shows up at `rs_addr` on the very next lookup that selects the affected window. Because the register path reads back combinationally, the same corruption is also visible on a read in the same cycle. A wrong enable or a wrong valid-bit decode turns expected hits into misses, or the reverse, one clock after `lk_valid`. An error in the index arithmetic appears as a result off by a multiple of the window size, and it is exposed most sharply at the first and last window and just outside the span.

// File: rtl/awx_pkg.sv
package awx_pkg;
  localparam int REG_AW   = 12;
  localparam int DW       = 32;
  localparam int MB_SHIFT = 20;
  localparam int EN_BIT   = 1;

  localparam logic [REG_AW-1:0] CTRL_OFF = 12'h004;
  localparam logic [REG_AW-1:0] SIZE_OFF = 12'h030;
  localparam logic [REG_AW-1:0] BASE_OFF = 12'h034;
  localparam logic [REG_AW-1:0] TBL_OFF  = 12'h200;
endpackage

// File: rtl/awx_regfile.sv
module awx_regfile
  import awx_pkg::*;
#(
  parameter int NWIN = 32,
  localparam int IW  = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              xl_en,
  output logic [2:0]        size_code,
  output logic [DW-1:0]     region_base,
  output logic [DW-1:0]     tbl_lo [NWIN],
  output logic [DW-1:0]     tbl_hi [NWIN]
);
  localparam logic [31:0] TBL_SPAN = 32'(NWIN * 8);

  logic [DW-1:0]     ctrl_q, ctrl_d;
  logic [2:0]        size_q, size_d;
  logic [DW-1:0]     base_q, base_d;
  logic              ctrl_we, size_we, base_we;
  logic [REG_AW-1:0] tbl_rel;
  logic              tbl_sel;
  logic [IW-1:0]     tbl_idx;
  logic              tbl_upper;

  // window table address decode
  always_comb begin
    tbl_rel   = addr - TBL_OFF;
    tbl_sel   = (addr >= TBL_OFF) && (32'(tbl_rel) < TBL_SPAN) && (tbl_rel[1:0] == 2'b00);
    tbl_idx   = tbl_rel[IW+2:3];
    tbl_upper = tbl_rel[2];
  end

  // scalar register next state
  always_comb begin
    ctrl_we = wr_en && (addr == CTRL_OFF);
    size_we = wr_en && (addr == SIZE_OFF);
    base_we = wr_en && (addr == BASE_OFF);
    ctrl_d  = wdata;
    size_d  = wdata[2:0];
    base_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      size_q <= '0;
      base_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (size_we) size_q <= size_d;
      if (base_we) base_q <= base_d;
    end
  end

  // one low/high pair per window
  for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
    logic [DW-1:0] lo_q, hi_q;
    logic          lo_we, hi_we;

    always_comb begin
      lo_we = wr_en && tbl_sel && (tbl_idx == IW'(gi)) && !tbl_upper;
      hi_we = wr_en && tbl_sel && (tbl_idx == IW'(gi)) &&  tbl_upper;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (lo_we) lo_q <= wdata;
        if (hi_we) hi_q <= wdata;
      end
    end

    assign tbl_lo[gi] = lo_q;
    assign tbl_hi[gi] = hi_q;
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (addr == CTRL_OFF)      rdata = ctrl_q;
    else if (addr == SIZE_OFF) rdata = {{(DW-3){1'b0}}, size_q};
    else if (addr == BASE_OFF) rdata = base_q;
    else if (tbl_sel)          rdata = tbl_upper ? tbl_hi[tbl_idx] : tbl_lo[tbl_idx];
  end

  assign xl_en       = ctrl_q[EN_BIT];
  assign size_code   = size_q;
  assign region_base = base_q;

  AST_ENABLE_TRACKS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CTRL_OFF) |=> (xl_en == $past(wdata[EN_BIT]))); // R10
  AST_SIZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == SIZE_OFF) |=> $stable(size_code)); // R9
  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == BASE_OFF) |=> $stable(region_base)); // R2
endmodule

// File: rtl/awx_index.sv
module awx_index
  import awx_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NWIN = 32,
  localparam int IW  = $clog2(NWIN)
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [2:0]    size_code,
  output logic [IW-1:0] idx,
  output logic          in_span,
  output logic [AW-1:0] offs
);
  logic [AW-1:0] diff, quot, mask;
  logic [4:0]    shamt;

  always_comb begin
    shamt   = 5'(MB_SHIFT) + {2'b00, size_code};
    diff    = addr - base;
    quot    = diff >> shamt;
    mask    = ({{(AW-1){1'b0}}, 1'b1} << shamt) - {{(AW-1){1'b0}}, 1'b1};
    offs    = diff & mask;
    idx     = quot[IW-1:0];
    in_span = (addr >= base) && (quot < AW'(NWIN));
  end
endmodule

// File: rtl/awx_stage.sv
module awx_stage
  import awx_pkg::*;
#(
  parameter int AW  = 32,
  localparam int OW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          xl_en,
  input  logic          in_span,
  input  logic [DW-1:0] win_lo,
  input  logic [DW-1:0] win_hi,
  input  logic [AW-1:0] offs,
  output logic          out_valid,
  output logic          out_hit,
  output logic          out_miss,
  output logic [OW-1:0] out_addr
);
  logic          hit_d, miss_d;
  logic [OW-1:0] addr_d;

  always_comb begin
    hit_d  = in_valid && xl_en && in_span && win_lo[0];
    miss_d = in_valid && !hit_d;
    addr_d = '0;
    if (hit_d) addr_d = {win_hi, win_lo & ~{{(DW-1){1'b0}}, 1'b1}} + OW'(offs);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_miss  <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      out_hit   <= hit_d;
      out_miss  <= miss_d;
      out_addr  <= addr_d;
    end
  end

  AST_MISS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !xl_en) |=> (out_miss && out_addr == '0)); // R5
  AST_INVALID_ENTRY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !win_lo[0]) |=> out_miss); // R6
  AST_OUT_OF_SPAN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_span) |=> out_miss); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_hit && !out_miss)); // R8
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({out_hit, out_miss})); // R8
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
  import awx_pkg::*;
#(
  parameter int NWIN = 32,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              lk_valid,
  input  logic [AW-1:0]     lk_addr,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic              rs_miss,
  output logic [2*DW-1:0]   rs_addr
);
  logic          xl_en;
  logic [2:0]    size_code;
  logic [DW-1:0] region_base;
  logic [DW-1:0] tbl_lo [NWIN];
  logic [DW-1:0] tbl_hi [NWIN];
  logic [IW-1:0] idx;
  logic          in_span;
  logic [AW-1:0] offs;

  awx_regfile #(.NWIN(NWIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .xl_en(xl_en),
    .size_code(size_code), .region_base(region_base),
    .tbl_lo(tbl_lo), .tbl_hi(tbl_hi)
  );

  awx_index #(.AW(AW), .NWIN(NWIN)) u_index (
    .addr(lk_addr), .base(AW'(region_base)), .size_code(size_code),
    .idx(idx), .in_span(in_span), .offs(offs)
  );

  awx_stage #(.AW(AW)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(lk_valid), .xl_en(xl_en),
    .in_span(in_span), .win_lo(tbl_lo[idx]), .win_hi(tbl_hi[idx]),
    .offs(offs), .out_valid(rs_valid), .out_hit(rs_hit),
    .out_miss(rs_miss), .out_addr(rs_addr)
  );

  AST_RESULT_FOLLOWS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid); // R8
  AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rs_miss |-> (rs_addr == '0)); // R5
endmodule

// File: tb/addr_window_xlate_test.sv
module addr_window_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        lk_valid;
  logic [31:0] lk_addr;
  logic        rs_valid, rs_hit, rs_miss;
  logic [63:0] rs_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [31:0] m_ctrl, m_base;
  logic [2:0]  m_size;
  logic [31:0] m_lo [32];
  logic [31:0] m_hi [32];

  always #2 clk = ~clk;

  addr_window_xlate uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .rs_valid(rs_valid), .rs_hit(rs_hit),
    .rs_miss(rs_miss), .rs_addr(rs_addr)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (a == 12'h004) m_ctrl = d;
    else if (a == 12'h030) m_size = d[2:0];
    else if (a == 12'h034) m_base = d;
    else if (a >= 12'h200 && a < 12'h300 && a[1:0] == 2'b00) begin
      if (a[2]) m_hi[a[7:3]] = d; else m_lo[a[7:3]] = d;
    end
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  function automatic logic [64:0] model(logic [31:0] a);
    logic [31:0] diff, q, mask;
    int sh;
    sh   = 20 + int'(m_size);
    diff = a - m_base;
    q    = diff >> sh;
    mask = (32'h1 << sh) - 32'h1;
    if (!m_ctrl[1] || a < m_base || q >= 32 || !m_lo[q[4:0]][0]) return {1'b0, 64'h0};
    return {1'b1, {m_hi[q[4:0]], m_lo[q[4:0]] & 32'hFFFF_FFFE} + {32'h0, diff & mask}};
  endfunction

  task automatic look(string req, logic [31:0] a);
    logic [64:0] e;
    e = model(a);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(req, {61'h0, rs_valid, rs_hit, rs_miss}, {61'h0, 1'b1, e[64], !e[64]});
    chk(req, rs_addr, e[63:0]);
  endtask

  task automatic fill(logic [31:0] tgt, logic [31:0] hi);
    for (int i = 0; i < 32; i++) begin
      wr(12'h200 + 12'(8 * i), (tgt + (32'(i) << (20 + int'(m_size)))) | 32'h1);
      wr(12'h204 + 12'(8 * i), hi + 32'(i));
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] span;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    lk_valid = 1'b0; lk_addr = '0;
    m_ctrl = '0; m_base = '0; m_size = '0;
    for (int i = 0; i < 32; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1", {61'h0, rs_valid, rs_hit, rs_miss}, 64'h0);
    rd_chk("R1", 12'h004, 32'h0);
    rd_chk("R1", 12'h030, 32'h0);
    rd_chk("R1", 12'h034, 32'h0);
    rd_chk("R1", 12'h2F8, 32'h0);

    // R2 readback and unmapped offsets
    wr(12'h004, 32'hA5A5_5A58);
    rd_chk("R2", 12'h004, 32'hA5A5_5A58);
    wr(12'h030, 32'hFFFF_FFFD);
    rd_chk("R2", 12'h030, 32'h5);
    wr(12'h034, 32'h1234_5678);
    rd_chk("R2", 12'h034, 32'h1234_5678);
    wr(12'h2FC, 32'hCAFE_0001);
    rd_chk("R2", 12'h2FC, 32'hCAFE_0001);
    wr(12'h200, 32'hBEEF_0003);
    rd_chk("R2", 12'h200, 32'hBEEF_0003);
    wr(12'h100, 32'hFFFF_FFFF);
    rd_chk("R2", 12'h100, 32'h0);
    rd_chk("R2", 12'h004, 32'hA5A5_5A58);
    wr(12'h300, 32'h7777_7777);
    rd_chk("R2", 12'h300, 32'h0);
    rd_chk("R2", 12'h200, 32'hBEEF_0003);

    // program consecutive 8 MB windows
    wr(12'h004, 32'h0);
    wr(12'h030, 32'h3);
    wr(12'h034, 32'h8000_0000);
    fill(32'h4000_0000, 32'h10);

    // R5 disabled
    look("R5", 32'h8000_0010);
    look("R5", 32'h8123_4560);

    // R3 / R4 enabled, first and last window
    wr(12'h004, 32'h2);
    look("R4", 32'h8000_0000);
    look("R3", 32'h807F_FFFF);
    look("R3", 32'h8080_0000);
    look("R4", 32'h8000_0000 + 31 * 32'h0080_0000 + 32'h0007_FFFC);

    // R7 outside span
    look("R7", 32'h7FFF_FFFF);
    look("R7", 32'h9000_0000);

    // R6 invalid entry
    wr(12'h228, 32'h4280_0000);
    look("R6", 32'h8000_0000 + 5 * 32'h0080_0000 + 32'h40);
    look("R4", 32'h8000_0000 + 6 * 32'h0080_0000 + 32'h40);

    // R8 idle cycle
    @(negedge clk);
    @(negedge clk);
    chk("R8", {61'h0, rs_valid, rs_hit, rs_miss}, 64'h0);

    // R9 size change takes effect on next lookup
    wr(12'h030, 32'h0);
    look("R9", 32'h8030_0123);
    wr(12'h030, 32'h7);
    look("R9", 32'h8030_0123);

    // R10 other control bits ignored
    wr(12'h004, 32'hFFFF_FFFD);
    look("R10", 32'h8000_0100);
    wr(12'h004, 32'h8000_0002);
    look("R10", 32'h8000_0100);

    // random tables, sizes and addresses
    for (int r = 0; r < 40; r++) begin
      wr(12'h030, $urandom);
      wr(12'h034, $urandom & 32'hFFF0_0000);
      wr(12'h004, $urandom);
      for (int k = 0; k < 6; k++) begin
        logic [4:0] w;
        w = 5'($urandom);
        wr(12'h200 + 12'(8 * int'(w)), $urandom);
        wr(12'h204 + 12'(8 * int'(w)), $urandom);
      end
      span = 32'h1 << (25 + int'(m_size));
      for (int k = 0; k < 8; k++) begin
        logic [31:0] a;
        a = m_base + ($urandom % (span + 32'h0100_0000)) - 32'h0080_0000;
        if (m_size == 3'd7) a = $urandom;
        look("R4", a);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule